// File: doc/BRIEF.md
# Sensor-Bus Slave Transaction Engine

This block sits in a slave device on a single-wire sensor bus and handles the framing of read and write transactions. It does not look at the wire itself. A lower bit-signaling layer decodes the pulses and passes in a start strobe, data-bit strobes with their values, and collision strobes. The engine collects a header made of an address and a direction flag. It looks up how wide the addressed register is and counts that many data bits. It then checks a trailing even-parity bit and an acknowledge bit.

A write reaches the register file only after the acknowledge slot closes on a fully correct transaction. When a transaction is rejected, the engine pulses a bus-error set line for the device status register. It also raises a flag that tells the signaling layer an attention request must go out. A new start strobe in the middle of a frame abandons the frame without any error. Surplus bits spill into the check slots. Missing bits leave the engine waiting for as long as it takes.

Top module: `sbus_txn_engine`

## Requirements
- R1: After `rst` or a `bus_reset` pulse the engine is idle, with `wr_en`, `ber_set`, `attn_need` and `ack_bit` low. A `bus_reset` discards any partial frame, and bits that follow it before the next start strobe have no effect.
- R2: A write that completes correctly produces a single-cycle `wr_en` pulse in the cycle after the acknowledge-bit strobe, carrying the captured address and data.
- R3: The frame is: start, then 4 address bits MSB first, then a direction bit (0 = write, 1 = read), then the data bits MSB first, then a parity bit, then an acknowledge bit. The register is 16 bits wide when bit `addr` of `WIDE_MASK` (default 16'hF0F0) is set and 8 bits wide otherwise. 8-bit data appears zero-extended in `wr_data`.
- R4: The transaction fails if any of these holds: the parity slot differs from the even parity of address, direction and data bits; a real collision occurred; or the acknowledge slot carries 0. On failure there is no write, `ber_set` pulses once in the cycle after the acknowledge strobe, and `attn_need` goes high one cycle later.
- R5: A start strobe in mid-frame abandons the frame with no write, no `ber_set` and no attention request, and begins a new frame.
- R6: Data bits beyond the register width fall into the parity and acknowledge slots and are judged there. Further bits are ignored until the next start strobe.
- R7: With fewer data bits than the width, the engine waits without limit. Sending the rest later with correct parity and acknowledge completes the transaction.
- R8: A collision strobe flagged as an attention request (`col_is_attn`=1) does not count against the acknowledge decision.
- R9: `attn_need` stays high until an `attn_issued` pulse or a `bus_reset` clears it.
- R10: A read transaction never asserts `wr_en`, but a read that fails raises `ber_set` and `attn_need` in the same way as a write.
- R11: While the engine waits for the acknowledge bit, `ack_bit` is 1 if and only if parity matched and no real collision occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset event from the signaling layer |
| start_stb | input | 1 | Start bit decoded |
| bit_stb | input | 1 | Data bit decoded |
| bit_val | input | 1 | Value of the decoded bit |
| col_stb | input | 1 | Bus collision observed |
| col_is_attn | input | 1 | The collision was an attention request |
| attn_issued | input | 1 | Attention request has been driven on the bus |
| wr_en | output | 1 | Register write commit pulse |
| wr_addr | output | 4 | Write address |
| wr_data | output | 16 | Write data, zero-extended for 8-bit registers |
| ber_set | output | 1 | Set the bus-error status bit |
| attn_need | output | 1 | An attention request is pending |
| ack_bit | output | 1 | Acknowledge value to drive in the acknowledge slot |

## Verification
A wrong bit count or a wrong width lookup shifts the parity and acknowledge slots. The first affected frame then shows a spurious `ber_set` or a missing `wr_en` one cycle after its last bit. A corrupted running parity or a stuck collision latch shows up even earlier, as a wrong `ack_bit` level while the engine waits for the acknowledge slot. A state that leaks across a start strobe or a bus reset shows up at the end of the next frame as a wrong write count or wrong write data.

// File: rtl/sbus_txn_pkg.sv
package sbus_txn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_PAR,
        ST_ACK
    } frame_st_e;

    // One-hot steering of the current strobe into a frame slot
    typedef struct packed {
        logic clr;
        logic hdr;
        logic dat;
        logic par;
        logic ack;
        logic col;
    } slot_en_t;

    function automatic logic slot_done(input logic [7:0] cnt, input logic [7:0] last);
        return cnt == last;
    endfunction

endpackage

// File: rtl/sbus_frame_ctl.sv
module sbus_frame_ctl
    import sbus_txn_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NARROW_W = 8,
    parameter int WIDE_W = 16,
    parameter logic [2**ADDR_W-1:0] WIDE_MASK = 16'hF0F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic              start_stb,
    input  logic              bit_stb,
    input  logic              col_stb,
    input  logic              col_is_attn,
    input  logic [ADDR_W-1:0] addr,
    output slot_en_t          slot,
    output frame_st_e         state
);
    localparam logic [7:0] HDR_LAST    = 8'(ADDR_W);
    localparam logic [7:0] NARROW_LAST = 8'(NARROW_W - 1);
    localparam logic [7:0] WIDE_LAST   = 8'(WIDE_W - 1);

    logic [7:0] cnt;
    logic [7:0] data_last;

    assign data_last = WIDE_MASK[addr] ? WIDE_LAST : NARROW_LAST;

    always_comb begin
        slot     = '0;
        slot.clr = bus_reset | start_stb;
        if (!slot.clr) begin
            if (bit_stb) begin
                case (state)
                    ST_HDR:  slot.hdr = 1'b1;
                    ST_DATA: slot.dat = 1'b1;
                    ST_PAR:  slot.par = 1'b1;
                    ST_ACK:  slot.ack = 1'b1;
                    default: ;
                endcase
            end
            slot.col = col_stb && !col_is_attn && (state != ST_IDLE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (start_stb) begin
            state <= ST_HDR;
            cnt   <= '0;
        end else if (bit_stb) begin
            case (state)
                ST_HDR: begin
                    if (slot_done(cnt, HDR_LAST)) begin
                        state <= ST_DATA;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 8'd1;
                    end
                end
                ST_DATA: begin
                    if (slot_done(cnt, data_last)) begin
                        state <= ST_PAR;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 8'd1;
                    end
                end
                ST_PAR:  state <= ST_ACK;
                ST_ACK:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sbus_frame_dp.sv
module sbus_frame_dp
    import sbus_txn_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_en_t          slot,
    input  frame_st_e         state,
    input  logic              bit_val,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              ber_set,
    output logic              ack_bit
);
    logic [ADDR_W:0]   hdr;
    logic [DATA_W-1:0] data;
    logic              par;
    logic              pbad;
    logic              col;
    logic              ack_good;

    assign addr     = hdr[ADDR_W:1];
    assign ack_good = !pbad && !col;
    assign ack_bit  = (state == ST_ACK) && ack_good;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr     <= '0;
            data    <= '0;
            par     <= 1'b0;
            pbad    <= 1'b0;
            col     <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            ber_set <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            ber_set <= 1'b0;
            if (slot.clr) begin
                hdr  <= '0;
                data <= '0;
                par  <= 1'b0;
                pbad <= 1'b0;
                col  <= 1'b0;
            end else begin
                if (slot.col) col <= 1'b1;
                if (slot.hdr) begin
                    hdr <= {hdr[ADDR_W-1:0], bit_val};
                    par <= par ^ bit_val;
                end
                if (slot.dat) begin
                    data <= {data[DATA_W-2:0], bit_val};
                    par  <= par ^ bit_val;
                end
                if (slot.par) pbad <= (bit_val != par);
                if (slot.ack) begin
                    if (ack_good && bit_val) begin
                        if (!hdr[0]) begin
                            wr_en   <= 1'b1;
                            wr_addr <= addr;
                            wr_data <= data;
                        end
                    end else begin
                        ber_set <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sbus_attn_flag.sv
module sbus_attn_flag (
    input  logic clk,
    input  logic rst,
    input  logic bus_reset,
    input  logic ber_set,
    input  logic attn_issued,
    output logic attn_need
);
    always_ff @(posedge clk) begin
        if (rst || bus_reset) attn_need <= 1'b0;
        else if (ber_set)     attn_need <= 1'b1;
        else if (attn_issued) attn_need <= 1'b0;
    end
endmodule

// File: rtl/sbus_txn_engine.sv
module sbus_txn_engine
    import sbus_txn_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NARROW_W = 8,
    parameter int WIDE_W = 16,
    parameter logic [2**ADDR_W-1:0] WIDE_MASK = 16'hF0F0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic              start_stb,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic              col_stb,
    input  logic              col_is_attn,
    input  logic              attn_issued,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WIDE_W-1:0] wr_data,
    output logic              ber_set,
    output logic              attn_need,
    output logic              ack_bit
);
    slot_en_t          slot;
    frame_st_e         state;
    logic [ADDR_W-1:0] addr;

    sbus_frame_ctl #(
        .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .WIDE_MASK(WIDE_MASK)
    ) u_ctl (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .start_stb(start_stb),
        .bit_stb(bit_stb), .col_stb(col_stb), .col_is_attn(col_is_attn),
        .addr(addr), .slot(slot), .state(state)
    );

    sbus_frame_dp #(
        .ADDR_W(ADDR_W), .DATA_W(WIDE_W)
    ) u_dp (
        .clk(clk), .rst(rst), .slot(slot), .state(state), .bit_val(bit_val),
        .addr(addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ber_set(ber_set), .ack_bit(ack_bit)
    );

    sbus_attn_flag u_attn (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .ber_set(ber_set),
        .attn_issued(attn_issued), .attn_need(attn_need)
    );

endmodule

// File: rtl/sbus_txn_chk.sv
module sbus_txn_chk (
    input logic clk,
    input logic rst,
    input logic bus_reset,
    input logic bit_stb,
    input logic bit_val,
    input logic attn_issued,
    input logic wr_en,
    input logic ber_set,
    input logic attn_need,
    input logic ack_bit
);
    // R2
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R4
    wr_ber_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && ber_set));

    // R11
    wr_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(bit_stb && bit_val && ack_bit));

    // R4
    ber_raises_attn_chk: assert property (@(posedge clk) disable iff (rst)
        ber_set && !bus_reset |=> attn_need);

    // R9
    attn_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(attn_need) |-> $past(ber_set));

    // R9
    attn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        attn_need && !attn_issued && !bus_reset |=> attn_need);

    // R1
    bus_reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !wr_en && !ber_set && !attn_need);
endmodule

bind sbus_txn_engine sbus_txn_chk u_chk (.*);

// File: tb/sim_sbus_txn_engine.sv
module sim_sbus_txn_engine;
    localparam logic [15:0] MASK = 16'hF0F0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_reset = 1'b0, start_stb = 1'b0, bit_stb = 1'b0, bit_val = 1'b0;
    logic col_stb = 1'b0, col_is_attn = 1'b0, attn_issued = 1'b0;
    logic wr_en, ber_set, attn_need, ack_bit;
    logic [3:0] wr_addr;
    logic [15:0] wr_data;

    int n_chk = 0, n_bad = 0;
    int wr_cnt = 0, ber_cnt = 0;
    logic [3:0] last_a = '0;
    logic [15:0] last_d = '0;
    bit done = 0;

    always #10 clk = ~clk;

    sbus_txn_engine u0 (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .start_stb(start_stb),
        .bit_stb(bit_stb), .bit_val(bit_val), .col_stb(col_stb),
        .col_is_attn(col_is_attn), .attn_issued(attn_issued), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ber_set(ber_set),
        .attn_need(attn_need), .ack_bit(ack_bit)
    );

    always @(negedge clk) begin
        if (wr_en) begin
            wr_cnt <= wr_cnt + 1;
            last_a <= wr_addr;
            last_d <= wr_data;
        end
        if (ber_set) ber_cnt <= ber_cnt + 1;
    end

    function automatic int width_of(input logic [3:0] a);
        return MASK[a] ? 16 : 8;
    endfunction

    function automatic logic par_of(input logic [3:0] a, input logic rw,
                                    input logic [15:0] d, input int w);
        logic p = ^a ^ rw;
        for (int i = 0; i < w; i++) p ^= d[i];
        return p;
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_stb = 1'b1; bit_val = b;
        @(negedge clk); bit_stb = 1'b0;
    endtask

    task automatic send_start();
        @(negedge clk); start_stb = 1'b1;
        @(negedge clk); start_stb = 1'b0;
    endtask

    task automatic send_col(input logic is_attn);
        @(negedge clk); col_stb = 1'b1; col_is_attn = is_attn;
        @(negedge clk); col_stb = 1'b0; col_is_attn = 1'b0;
    endtask

    task automatic pulse_bus_reset();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic send_hdr(input logic [3:0] a, input logic rw);
        send_start();
        for (int i = 3; i >= 0; i--) send_bit(a[i]);
        send_bit(rw);
    endtask

    task automatic clear_attn();
        @(negedge clk); attn_issued = 1'b1;
        @(negedge clk); attn_issued = 1'b0;
    endtask

    // col_mode: 0 none, 1 real collision, 2 attention-request collision
    task automatic run_frame(input logic [3:0] a, input logic rw, input logic [15:0] d,
                             input bit flip, input logic ackv, input int col_mode,
                             input string tag);
        int w = width_of(a);
        int w0 = wr_cnt, b0 = ber_cnt;
        logic p = par_of(a, rw, d, w);
        bit good = !flip && (col_mode != 1);
        bit ok = good && ackv;
        send_hdr(a, rw);
        for (int i = w - 1; i >= 0; i--) begin
            send_bit(d[i]);
            if (i == w - 2 && col_mode != 0) send_col(col_mode == 2);
        end
        send_bit(p ^ flip);
        chk({tag, " R11 ack_bit"}, 32'(ack_bit), 32'(good));
        send_bit(ackv);
        @(negedge clk);
        if (ok && !rw) begin
            chk({tag, " R2 write count"}, wr_cnt - w0, 1);
            chk({tag, " R3 addr"}, 32'(last_a), 32'(a));
            chk({tag, " R3 data"}, 32'(last_d), w == 8 ? 32'(d[7:0]) : 32'(d));
            chk({tag, " R2 no ber"}, ber_cnt - b0, 0);
        end else if (ok) begin
            chk({tag, " R10 read no write"}, wr_cnt - w0, 0);
            chk({tag, " R10 read no ber"}, ber_cnt - b0, 0);
        end else begin
            chk({tag, " R4 no write"}, wr_cnt - w0, 0);
            chk({tag, " R4 ber count"}, ber_cnt - b0, 1);
            chk({tag, " R4 attn_need"}, 32'(attn_need), 1);
            repeat (5) @(negedge clk);
            chk({tag, " R9 attn held"}, 32'(attn_need), 1);
            clear_attn();
            @(negedge clk);
            chk({tag, " R9 attn cleared"}, 32'(attn_need), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int w0, b0;
        logic [15:0] d16;
        logic p8;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 wr_en", 32'(wr_en), 0);
        chk("R1 ber_set", 32'(ber_set), 0);
        chk("R1 attn_need", 32'(attn_need), 0);
        chk("R1 ack_bit", 32'(ack_bit), 0);

        // R3 widths
        run_frame(4'd4, 1'b0, 16'hA55A, 0, 1'b1, 0, "wide");
        run_frame(4'd1, 1'b0, 16'hFFC3, 0, 1'b1, 0, "narrow");
        run_frame(4'd0, 1'b1, 16'h0081, 0, 1'b0, 0, "R10 read fail");
        run_frame(4'd9, 1'b0, 16'h1234, 0, 1'b1, 2, "R8 attn collision");

        // R5 start mid-frame
        w0 = wr_cnt; b0 = ber_cnt;
        send_hdr(4'd2, 1'b0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        run_frame(4'd3, 1'b0, 16'h0066, 0, 1'b1, 0, "R5 after abort");
        chk("R5 one write only", wr_cnt - w0, 1);
        chk("R5 no ber", ber_cnt - b0, 0);
        chk("R5 no attn", 32'(attn_need), 0);

        // R7 missing bits, long wait
        w0 = wr_cnt; b0 = ber_cnt;
        d16 = 16'h00B7;
        send_hdr(4'd1, 1'b0);
        for (int i = 7; i >= 3; i--) send_bit(d16[i]);
        repeat (500) @(negedge clk);
        chk("R7 no write while waiting", wr_cnt - w0, 0);
        chk("R7 no ber while waiting", ber_cnt - b0, 0);
        for (int i = 2; i >= 0; i--) send_bit(d16[i]);
        send_bit(par_of(4'd1, 1'b0, d16, 8));
        send_bit(1'b1);
        @(negedge clk);
        chk("R7 completes", wr_cnt - w0, 1);
        chk("R7 data", 32'(last_d), 32'h00B7);

        // R6 surplus bits that happen to land correctly: 16 bits to 8-bit reg
        w0 = wr_cnt; b0 = ber_cnt;
        p8 = par_of(4'd2, 1'b0, 16'h003C, 8);
        d16 = {8'h3C, p8, 1'b1, 6'b101101};
        send_hdr(4'd2, 1'b0);
        for (int i = 15; i >= 0; i--) send_bit(d16[i]);
        send_bit(1'b0); send_bit(1'b0);
        @(negedge clk);
        chk("R6 surplus match write", wr_cnt - w0, 1);
        chk("R6 surplus match data", 32'(last_d), 32'h003C);
        chk("R6 surplus ignored ber", ber_cnt - b0, 0);

        // R6 surplus bits that do not match
        w0 = wr_cnt; b0 = ber_cnt;
        d16 = {8'h3C, ~p8, 1'b1, 6'b000000};
        send_hdr(4'd2, 1'b0);
        for (int i = 15; i >= 0; i--) send_bit(d16[i]);
        send_bit(p8); send_bit(1'b1);
        @(negedge clk);
        chk("R6 surplus mismatch no write", wr_cnt - w0, 0);
        chk("R6 surplus mismatch one ber", ber_cnt - b0, 1);
        chk("R6 attn", 32'(attn_need), 1);

        // R1 bus reset clears attention and discards a partial frame
        pulse_bus_reset();
        @(negedge clk);
        chk("R1 bus_reset clears attn", 32'(attn_need), 0);
        w0 = wr_cnt; b0 = ber_cnt;
        send_hdr(4'd5, 1'b0);
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        pulse_bus_reset();
        for (int i = 0; i < 12; i++) send_bit(1'b0);
        @(negedge clk);
        chk("R1 discarded no write", wr_cnt - w0, 0);
        chk("R1 discarded no ber", ber_cnt - b0, 0);

        // random mix
        for (int k = 0; k < 60; k++) begin
            logic [3:0] a = 4'($urandom_range(0, 15));
            logic rw = 1'($urandom_range(0, 3) == 0);
            logic [15:0] d = 16'($urandom);
            int f = $urandom_range(0, 5);
            run_frame(a, rw, d, f == 1, (f == 2) ? 1'b0 : 1'b1,
                      (f == 3) ? 1 : (f == 4) ? 2 : 0, "rand R4 R8");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule